// File: doc/BRIEF.md
# Software-Managed Translation Entry Array

This block is a small, fully associative array of translation entries that privileged software fills and inspects itself. Software does not touch the entries directly. It loads a set of staging registers and strobes one of three operations: search, read or write. A virtual page-pair tag sits in the high staging register. Two physical halves, one for the even page and one for the odd page, sit in the two low staging registers. A slot/control word carries a slot number, a page-size code and a not-present flag. The current address-space identifier is a separate input.

Each entry stores a virtual pair tag (address bits 13 and up), an address-space ID, a global bit, a present bit, a 6-bit page-size code, and two 64-bit physical halves. The halves use the same bit layout as the low staging registers, so whole words move between the registers and the array. The page-size code sets how many low tag bits a search ignores: a pair spans 2^(size+1) bytes. One cycle after each accepted strobe, the block returns the updated values of all four staging registers, together with a one-cycle done pulse. Software writes those values back into its registers.

Top module: `swtlb_core`

## Requirements
- R1: During and after reset the four staging outputs are zero and done is low. Every entry is not present, so a search before any write misses.
- R2: A search matches an entry only when all of these hold: the entry is present; the entry is global or its stored ID equals the current ID; and the stored tag and the search tag (high register bits VA_W-1:13) are equal once both are shifted right by (size-12), where size is the entry's size code. The shift is zero when the size is 12 or below. The search tag's bits 12:0 play no part.
- R3: On a search hit, the output control word holds the matching slot number in bits 11:0 and the entry's size code in bits 29:24, with bit 31 cleared. Its other bits pass through from the input. The lowest-numbered matching slot wins.
- R4: On a search miss, the output control word equals the input with bit 31 set.
- R5: A write to slot n (control bits 11:0, below ENTRIES) marks slot n present. It stores the high register's tag bits, the current ID, the size code from control bits 29:24, both low registers unchanged, and a global bit equal to the AND of bit 6 of the two low registers.
- R6: A write whose slot number is ENTRIES or above changes no entry. A slot number is never wrapped onto a lower slot.
- R7: A read of a present slot n returns these values. The high output holds the stored tag shifted left by 13 bits, with every other bit zero. Each low output holds its stored half with bit 6 replaced by the entry's global bit. The control output carries the entry's size code in bits 29:24 and has bit 31 cleared.
- R8: A read of a slot that is not present, or whose number is ENTRIES or above, returns zero on all three address outputs and the input control word with bit 31 set.
- R9: The opcode values are 0 = search, 1 = read and 2 = write. A strobe with any of them raises done for exactly one cycle, in the cycle after the strobe, and the updated outputs appear in that same cycle. Search and write pass the high and low inputs straight through to the outputs.
- R10: With no strobe, or with opcode 3, done stays low, the outputs hold their values and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | 0 search, 1 read, 2 write, 3 reserved |
| ehi_in | input | 64 | Virtual pair tag staging register |
| elo0_in | input | 64 | Even-page physical half staging register |
| elo1_in | input | 64 | Odd-page physical half staging register |
| idx_in | input | 32 | Slot/control word: slot 11:0, size 29:24, not-present 31 |
| asid_in | input | ASID_W | Current address-space identifier |
| ehi_out | output | 64 | Updated high staging value |
| elo0_out | output | 64 | Updated even-half staging value |
| elo1_out | output | 64 | Updated odd-half staging value |
| idx_out | output | 32 | Updated control word |
| op_done | output | 1 | One-cycle completion pulse |

## Verification
Every operation's results are due exactly one cycle after its strobe. The done pulse and all four outputs come from a single register stage. The driver queues the expected outputs when it raises the strobe. The monitor samples on the falling edge after the next rising edge and pops an item only while done is high, so a pulse that is late, missing or extra shows up as a mismatch or an empty queue. The checks for a reserved opcode watch the two falling edges after the strobe. They confirm that done stays low and that the outputs keep their earlier values.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;

  typedef enum logic [1:0] {
    OP_SRCH = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2,
    OP_NONE = 2'd3
  } tlb_op_e;

  // control word field positions (decoded by software)
  localparam int IX_IDX_LSB = 0;
  localparam int IX_IDX_W   = 12;
  localparam int IX_PS_LSB  = 24;
  localparam int IX_PS_W    = 6;
  localparam int IX_NE_BIT  = 31;
  // global bit inside a physical half
  localparam int LO_G_BIT   = 6;
  // lowest address bit of the pair tag
  localparam int PAIR_LSB   = 13;

  // number of low tag bits a given size code leaves out of the compare
  function automatic int unsigned pair_shift(input logic [IX_PS_W-1:0] ps);
    if (ps > 6'd12) return 32'(ps) - 32'd12;
    return 32'd0;
  endfunction

  // control word with the flag and size fields replaced
  function automatic logic [31:0] idx_set(input logic [31:0] idx,
                                          input logic ne,
                                          input logic [IX_PS_W-1:0] ps);
    logic [31:0] r;
    r = idx;
    r[IX_NE_BIT] = ne;
    r[IX_PS_LSB +: IX_PS_W] = ps;
    return r;
  endfunction

  // control word describing a hit on a given slot
  function automatic logic [31:0] idx_hit(input logic [31:0] idx,
                                          input logic [IX_IDX_W-1:0] slot,
                                          input logic [IX_PS_W-1:0] ps);
    logic [31:0] r;
    r = idx_set(idx, 1'b0, ps);
    r[IX_IDX_LSB +: IX_IDX_W] = slot;
    return r;
  endfunction

  // physical half with its global bit forced to the entry's value
  function automatic logic [63:0] lo_with_g(input logic [63:0] lo, input logic g);
    logic [63:0] r;
    r = lo;
    r[LO_G_BIT] = g;
    return r;
  endfunction

endpackage

// File: rtl/swtlb_entry.sv
module swtlb_entry
  import swtlb_pkg::*;
#(
  parameter int TAG_W  = 35,
  parameter int ASID_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_g,
  input  logic [IX_PS_W-1:0] wr_ps,
  input  logic [63:0]       wr_lo0,
  input  logic [63:0]       wr_lo1,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic [ASID_W-1:0] look_asid,
  output logic              hit,
  output logic              e_q,
  output logic              g_q,
  output logic [IX_PS_W-1:0] ps_q,
  output logic [TAG_W-1:0]  tag_q,
  output logic [63:0]       lo0_q,
  output logic [63:0]       lo1_q
);

  logic [ASID_W-1:0] asid_q;
  logic [TAG_W-1:0]  tag_diff;
  int unsigned       cmp_shift;
  logic              id_ok;
  logic              tag_ok;

  // only the present bit needs a reset; contents are ignored until written
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     e_q <= 1'b0;
    else if (wr_en) e_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q  <= wr_tag;
      asid_q <= wr_asid;
      g_q    <= wr_g;
      ps_q   <= wr_ps;
      lo0_q  <= wr_lo0;
      lo1_q  <= wr_lo1;
    end
  end

  assign tag_diff  = tag_q ^ look_tag;
  assign cmp_shift = pair_shift(ps_q);
  assign tag_ok    = ((tag_diff >> cmp_shift) == '0);
  assign id_ok     = g_q || (asid_q == look_asid);
  assign hit       = e_q && id_ok && tag_ok;

endmodule

// File: rtl/swtlb_prio.sv
module swtlb_prio #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  // walk downward so the lowest requesting slot is the last assignment
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/swtlb_core.sv
module swtlb_core
  import swtlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 48,
  parameter int ASID_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic [63:0]       ehi_in,
  input  logic [63:0]       elo0_in,
  input  logic [63:0]       elo1_in,
  input  logic [31:0]       idx_in,
  input  logic [ASID_W-1:0] asid_in,
  output logic [63:0]       ehi_out,
  output logic [63:0]       elo0_out,
  output logic [63:0]       elo1_out,
  output logic [31:0]       idx_out,
  output logic              op_done
);

  localparam int TAG_W = VA_W - PAIR_LSB;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tlb_op_e              op;
  logic                 srch_fire, rd_fire, wr_fire, any_fire;
  logic [IX_IDX_W-1:0]  slot_fld;
  logic                 slot_ok;
  logic [IDX_W-1:0]     slot;
  logic [TAG_W-1:0]     look_tag;
  logic                 wr_g;
  logic [IX_PS_W-1:0]   wr_ps;

  logic [ENTRIES-1:0]   wr_sel;
  logic [ENTRIES-1:0]   hit_vec;
  logic [ENTRIES-1:0]   e_vec;
  logic [ENTRIES-1:0]   g_vec;
  logic [IX_PS_W-1:0]   ps_arr  [ENTRIES];
  logic [TAG_W-1:0]     tag_arr [ENTRIES];
  logic [63:0]          lo0_arr [ENTRIES];
  logic [63:0]          lo1_arr [ENTRIES];

  logic                 hit_any;
  logic [IDX_W-1:0]     hit_idx;
  logic                 sel_ok;

  logic [63:0]          rd_ehi, rd_lo0, rd_lo1;
  logic [31:0]          rd_idx, srch_idx;

  // operation decode
  assign op        = tlb_op_e'(op_code);
  assign srch_fire = op_valid && (op == OP_SRCH);
  assign rd_fire   = op_valid && (op == OP_RD);
  assign wr_fire   = op_valid && (op == OP_WR);
  assign any_fire  = srch_fire || rd_fire || wr_fire;

  // slot and write fields taken from the staging registers
  assign slot_fld  = idx_in[IX_IDX_LSB +: IX_IDX_W];
  assign slot_ok   = (32'(slot_fld) < 32'(ENTRIES));
  assign slot      = slot_fld[IDX_W-1:0];
  assign look_tag  = ehi_in[VA_W-1:PAIR_LSB];
  assign wr_g      = elo0_in[LO_G_BIT] & elo1_in[LO_G_BIT];
  assign wr_ps     = idx_in[IX_PS_LSB +: IX_PS_W];

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
    assign wr_sel[gi] = wr_fire && slot_ok && (slot == IDX_W'(gi));

    swtlb_entry #(
      .TAG_W  (TAG_W),
      .ASID_W (ASID_W)
    ) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_sel[gi]),
      .wr_tag    (look_tag),
      .wr_asid   (asid_in),
      .wr_g      (wr_g),
      .wr_ps     (wr_ps),
      .wr_lo0    (elo0_in),
      .wr_lo1    (elo1_in),
      .look_tag  (look_tag),
      .look_asid (asid_in),
      .hit       (hit_vec[gi]),
      .e_q       (e_vec[gi]),
      .g_q       (g_vec[gi]),
      .ps_q      (ps_arr[gi]),
      .tag_q     (tag_arr[gi]),
      .lo0_q     (lo0_arr[gi]),
      .lo1_q     (lo1_arr[gi])
    );
  end

  swtlb_prio #(
    .N  (ENTRIES),
    .IW (IDX_W)
  ) u_prio (
    .req (hit_vec),
    .any (hit_any),
    .idx (hit_idx)
  );

  // search result
  assign srch_idx = hit_any ? idx_hit(idx_in, IX_IDX_W'(hit_idx), ps_arr[hit_idx])
                            : idx_set(idx_in, 1'b1, wr_ps);

  // read result
  assign sel_ok = slot_ok && e_vec[slot];
  assign rd_ehi = sel_ok ? (64'(tag_arr[slot]) << PAIR_LSB) : 64'd0;
  assign rd_lo0 = sel_ok ? lo_with_g(lo0_arr[slot], g_vec[slot]) : 64'd0;
  assign rd_lo1 = sel_ok ? lo_with_g(lo1_arr[slot], g_vec[slot]) : 64'd0;
  assign rd_idx = sel_ok ? idx_set(idx_in, 1'b0, ps_arr[slot])
                         : idx_set(idx_in, 1'b1, wr_ps);

  // staging outputs: one register stage for every operation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ehi_out  <= '0;
      elo0_out <= '0;
      elo1_out <= '0;
      idx_out  <= '0;
      op_done  <= 1'b0;
    end else begin
      op_done <= any_fire;
      if (rd_fire) begin
        ehi_out  <= rd_ehi;
        elo0_out <= rd_lo0;
        elo1_out <= rd_lo1;
        idx_out  <= rd_idx;
      end else if (srch_fire || wr_fire) begin
        ehi_out  <= ehi_in;
        elo0_out <= elo0_in;
        elo1_out <= elo1_in;
        idx_out  <= srch_fire ? srch_idx : idx_in;
      end
    end
  end

endmodule

// File: rtl/swtlb_core_chk.sv
module swtlb_core_chk #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid,
  input logic [1:0]         op_code,
  input logic               srch_fire,
  input logic               rd_fire,
  input logic               wr_fire,
  input logic               hit_any,
  input logic [IDX_W-1:0]   hit_idx,
  input logic [ENTRIES-1:0] wr_sel,
  input logic               slot_ok,
  input logic               sel_ok,
  input logic [63:0]        ehi_out,
  input logic [63:0]        elo0_out,
  input logic [63:0]        elo1_out,
  input logic [31:0]        idx_out,
  input logic               op_done
);

  // R9
  done_follows_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code != 2'd3) |=> op_done);

  // R10
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_code != 2'd3) |=> !op_done);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_code != 2'd3) |=>
      ($stable(ehi_out) && $stable(elo0_out) && $stable(elo1_out) && $stable(idx_out)));

  // R3
  hit_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_fire && hit_any) |=>
      (idx_out[11:0] == 12'($past(hit_idx)) && !idx_out[31]));

  // R4
  miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_fire && !hit_any) |=> idx_out[31]);

  // R5
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && slot_ok) |-> ($countones(wr_sel) == 1));

  // R6
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !slot_ok) |-> (wr_sel == '0));

  // R10
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |-> (wr_sel == '0));

  // R8
  rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !sel_ok) |=>
      (ehi_out == 64'd0 && elo0_out == 64'd0 && elo1_out == 64'd0 && idx_out[31]));

endmodule

bind swtlb_core swtlb_core_chk #(
  .ENTRIES (ENTRIES),
  .IDX_W   (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .srch_fire (srch_fire),
  .rd_fire   (rd_fire),
  .wr_fire   (wr_fire),
  .hit_any   (hit_any),
  .hit_idx   (hit_idx),
  .wr_sel    (wr_sel),
  .slot_ok   (slot_ok),
  .sel_ok    (sel_ok),
  .ehi_out   (ehi_out),
  .elo0_out  (elo0_out),
  .elo1_out  (elo1_out),
  .idx_out   (idx_out),
  .op_done   (op_done)
);

// File: tb/swtlb_core_tb_top.sv
`timescale 1ns/1ps
module swtlb_core_tb_top;

  localparam int ENTRIES = 16;
  localparam int VA_W    = 48;
  localparam int ASID_W  = 10;
  localparam int TAG_W   = VA_W - 13;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              op_valid;
  logic [1:0]        op_code;
  logic [63:0]       ehi_in, elo0_in, elo1_in;
  logic [31:0]       idx_in;
  logic [ASID_W-1:0] asid_in;
  logic [63:0]       ehi_out, elo0_out, elo1_out;
  logic [31:0]       idx_out;
  logic              op_done;

  always #4 clk = ~clk;

  swtlb_core #(.ENTRIES(ENTRIES), .VA_W(VA_W), .ASID_W(ASID_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .ehi_in(ehi_in), .elo0_in(elo0_in), .elo1_in(elo1_in), .idx_in(idx_in),
    .asid_in(asid_in), .ehi_out(ehi_out), .elo0_out(elo0_out),
    .elo1_out(elo1_out), .idx_out(idx_out), .op_done(op_done)
  );

  typedef struct {
    string       req;
    logic [63:0] ehi, lo0, lo1;
    logic [31:0] idx;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   ended  = 0;

  // bench-side model of the array
  bit               m_e    [ENTRIES];
  bit               m_g    [ENTRIES];
  logic [5:0]       m_ps   [ENTRIES];
  logic [ASID_W-1:0] m_asid[ENTRIES];
  logic [TAG_W-1:0] m_tag  [ENTRIES];
  logic [63:0]      m_lo0  [ENTRIES];
  logic [63:0]      m_lo1  [ENTRIES];

  function automatic logic [63:0] mk_ehi(logic [TAG_W-1:0] tag, logic [12:0] junk);
    return {16'h0, tag, junk};
  endfunction

  function automatic logic [31:0] mk_idx(int slot, logic [5:0] ps);
    logic [31:0] r;
    r = 32'h4010_0000;           // bits 30 and 20 carry pass-through junk
    r[11:0]  = 12'(slot);
    r[29:24] = ps;
    return r;
  endfunction

  task automatic check1(string req, bit ok, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per done pulse
  exp_t cur;
  always @(negedge clk) begin
    if (rst_n && op_done && !ended) begin
      if (exp_q.size() == 0) begin
        check1("R9 spurious done", 1'b0, 64'd1, 64'd0);
      end else begin
        cur = exp_q.pop_front();
        n_chk++;
        if (ehi_out !== cur.ehi || elo0_out !== cur.lo0 ||
            elo1_out !== cur.lo1 || idx_out !== cur.idx) begin
          n_fail++;
          $display("FAIL %s: actual ehi=%h lo0=%h lo1=%h idx=%h expected ehi=%h lo0=%h lo1=%h idx=%h",
                   cur.req, ehi_out, elo0_out, elo1_out, idx_out,
                   cur.ehi, cur.lo0, cur.lo1, cur.idx);
        end
      end
    end
  end

  // driver: computes the expected staging values, then strobes one op
  task automatic issue(logic [1:0] op, logic [63:0] ehi, logic [63:0] lo0,
                       logic [63:0] lo1, logic [31:0] idx, logic [ASID_W-1:0] asid,
                       string req);
    exp_t x;
    int   slot;
    logic [TAG_W-1:0] stag;
    x.req = req; x.ehi = ehi; x.lo0 = lo0; x.lo1 = lo1; x.idx = idx;
    slot = int'(idx[11:0]);
    stag = ehi[VA_W-1:13];
    if (op == 2'd0) begin
      x.idx[31] = 1'b1;
      for (int i = 0; i < ENTRIES; i++) begin
        int unsigned sh;
        sh = (m_ps[i] > 6'd12) ? (32'(m_ps[i]) - 12) : 0;
        if (m_e[i] && (m_g[i] || m_asid[i] == asid) &&
            ((m_tag[i] >> sh) == (stag >> sh))) begin
          x.idx[31]    = 1'b0;
          x.idx[29:24] = m_ps[i];
          x.idx[11:0]  = 12'(i);
          break;
        end
      end
    end else if (op == 2'd1) begin
      if (slot < ENTRIES && m_e[slot]) begin
        x.ehi = {16'h0, m_tag[slot], 13'h0};
        x.lo0 = m_lo0[slot]; x.lo0[6] = m_g[slot];
        x.lo1 = m_lo1[slot]; x.lo1[6] = m_g[slot];
        x.idx[31] = 1'b0;
        x.idx[29:24] = m_ps[slot];
      end else begin
        x.ehi = '0; x.lo0 = '0; x.lo1 = '0;
        x.idx[31] = 1'b1;
      end
    end else if (op == 2'd2) begin
      if (slot < ENTRIES) begin
        m_e[slot] = 1'b1; m_g[slot] = lo0[6] & lo1[6]; m_ps[slot] = idx[29:24];
        m_asid[slot] = asid; m_tag[slot] = stag;
        m_lo0[slot] = lo0; m_lo1[slot] = lo1;
      end
    end
    @(negedge clk);
    op_valid = 1'b1; op_code = op; ehi_in = ehi; elo0_in = lo0;
    elo1_in = lo1; idx_in = idx; asid_in = asid;
    exp_q.push_back(x);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  localparam logic [TAG_W-1:0] TAG_A = 35'h1_2345_6780;
  localparam logic [TAG_W-1:0] TAG_B = 35'h4_0000_0200;
  localparam logic [TAG_W-1:0] TAG_C = 35'h2_AAAA_5555;
  localparam logic [63:0] LO_P = 64'h4000_00AB_CDE0_0053; // bit6 = 1
  localparam logic [63:0] LO_Q = 64'h8000_0012_3450_0013; // bit6 = 0
  localparam logic [63:0] LO_R = 64'h2000_0077_0000_0047; // bit6 = 1
  localparam logic [63:0] LO_S = 64'h6000_0055_1000_00C3; // bit6 = 1

  initial begin
    #(8 * 20000);
    if (!ended) begin
      ended = 1;
      check1("watchdog", 1'b0, 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] h_ehi, h_lo0, h_lo1;
    logic [31:0] h_idx;
    for (int i = 0; i < ENTRIES; i++) begin
      m_e[i] = 0; m_g[i] = 0; m_ps[i] = '0; m_asid[i] = '0;
      m_tag[i] = '0; m_lo0[i] = '0; m_lo1[i] = '0;
    end
    rst_n = 1'b0; op_valid = 1'b0; op_code = 2'd0; ehi_in = '0;
    elo0_in = '0; elo1_in = '0; idx_in = '0; asid_in = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check1("R1 reset outputs", (ehi_out | elo0_out | elo1_out | 64'(idx_out)) == 64'd0 && !op_done,
           ehi_out | 64'(idx_out) | 64'(op_done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R4: empty array misses
    issue(2'd0, mk_ehi(TAG_A, 13'h0), LO_P, LO_Q, mk_idx(2, 6'd12), 10'd5, "R1 R4 search empty");

    // R5: writes
    issue(2'd2, mk_ehi(TAG_A, 13'h1ABC), LO_P, LO_Q, mk_idx(3, 6'd12), 10'd5, "R5 write slot3");
    issue(2'd2, mk_ehi(TAG_A, 13'h0), LO_R, LO_S, mk_idx(5, 6'd12), 10'd7, "R5 write slot5 global");
    issue(2'd2, mk_ehi(TAG_B, 13'h0), LO_Q, LO_P, mk_idx(7, 6'd21), 10'd5, "R5 write slot7 big page");

    // R2 R3: ASID match, lowest slot wins
    issue(2'd0, mk_ehi(TAG_A, 13'h1FFF), '0, '0, mk_idx(0, 6'd0), 10'd5, "R3 search lowest slot");
    // R2: global entry matches foreign ASID
    issue(2'd0, mk_ehi(TAG_A, 13'h0), '0, '0, mk_idx(0, 6'd0), 10'd9, "R2 search global");
    // R2 R4: one tag bit off with size 12
    issue(2'd0, mk_ehi(TAG_A ^ 35'h1, 13'h0), '0, '0, mk_idx(0, 6'd0), 10'd5, "R4 search tag differs");
    // R2: size 21 ignores low 9 tag bits
    issue(2'd0, mk_ehi(TAG_B ^ 35'h1FF, 13'h0), '0, '0, mk_idx(0, 6'd0), 10'd5, "R2 search masked hit");
    issue(2'd0, mk_ehi(TAG_B ^ 35'h200, 13'h0), '0, '0, mk_idx(0, 6'd0), 10'd5, "R2 search above mask");
    // R2: ASID mismatch on non-global entry
    issue(2'd0, mk_ehi(TAG_B, 13'h0), '0, '0, mk_idx(0, 6'd0), 10'd6, "R2 search asid mismatch");

    // R7: reads
    issue(2'd1, 64'hFFFF_0000_0000_1234, '1, '1, mk_idx(3, 6'd0), 10'd0, "R7 read slot3");
    issue(2'd1, '0, '0, '0, mk_idx(5, 6'd3), 10'd0, "R7 read slot5 global");
    issue(2'd1, '0, '0, '0, mk_idx(7, 6'd0), 10'd0, "R7 read slot7");
    // R8: empty and out-of-range reads
    issue(2'd1, 64'h1111, 64'h2222, 64'h3333, mk_idx(9, 6'd4), 10'd0, "R8 read empty");
    issue(2'd1, 64'h1111, 64'h2222, 64'h3333, mk_idx(100, 6'd4), 10'd0, "R8 read out of range");

    // R6: out-of-range write (low bits alias slot 8) changes nothing
    issue(2'd2, mk_ehi(TAG_C, 13'h0), LO_P, LO_Q, mk_idx(24, 6'd12), 10'd5, "R6 write out of range");
    issue(2'd0, mk_ehi(TAG_C, 13'h0), '0, '0, mk_idx(0, 6'd0), 10'd5, "R6 search after bad write");
    issue(2'd1, '0, '0, '0, mk_idx(8, 6'd0), 10'd0, "R6 read aliased slot");

    // R10: reserved opcode holds outputs and produces no done
    h_ehi = ehi_out; h_lo0 = elo0_out; h_lo1 = elo1_out; h_idx = idx_out;
    @(negedge clk);
    op_valid = 1'b1; op_code = 2'd3; ehi_in = mk_ehi(TAG_C, 13'h0);
    elo0_in = LO_P; elo1_in = LO_Q; idx_in = mk_idx(8, 6'd12); asid_in = 10'd5;
    @(negedge clk);
    op_valid = 1'b0;
    check1("R10 reserved no done", !op_done, 64'(op_done), 64'd0);
    check1("R10 reserved holds outputs",
           ehi_out == h_ehi && elo0_out == h_lo0 && elo1_out == h_lo1 && idx_out == h_idx,
           ehi_out, h_ehi);
    @(negedge clk);
    check1("R10 idle no done", !op_done, 64'(op_done), 64'd0);
    issue(2'd1, '0, '0, '0, mk_idx(8, 6'd0), 10'd0, "R10 array unchanged");

    // R5: overwrite slot3 with another ASID
    issue(2'd2, mk_ehi(TAG_C, 13'h0), LO_S, LO_R, mk_idx(3, 6'd14), 10'd2, "R5 overwrite slot3");
    issue(2'd0, mk_ehi(TAG_C ^ 35'h3, 13'h0), '0, '0, mk_idx(0, 6'd0), 10'd2, "R2 search overwritten");
    issue(2'd0, mk_ehi(TAG_A, 13'h0), '0, '0, mk_idx(0, 6'd0), 10'd5, "R3 old tag falls to slot5");

    repeat (3) @(negedge clk);
    check1("R9 all results seen", exp_q.size() == 0, 64'(exp_q.size()), 64'd0);
    ended = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule